// File: doc/BRIEF.md
# External-Interrupt Configuration Register Bank

This block is the software-visible configuration store of an external-interrupt controller. A simple register bus writes it and reads it back. The bus has a word address, 32-bit write data, byte strobes, a write enable and a combinational read-data return. The stored fields are decoded onto dedicated outputs that feed the interrupt logic: the run (enable) status, the filter/debounce clock choice, the non-maskable line setup, event routing, asynchronous mode, debouncer enables, the debounce prescaler, and per-pin sense and filter settings.

Most configuration may only change while the controller is stopped. A small state machine in the control word holds the run state. It has two states: `ST_OFF` (stopped) and `ST_ON` (running). Transition *arm* moves `ST_OFF` to `ST_ON` on a control write with run=1. Transition *disarm* moves `ST_ON` to `ST_OFF` on a control write with run=0. Every other cycle keeps the state. While the state is `ST_ON`, writes to protected fields are dropped without any error, and those fields read back their old contents. Protection is judged from the state held before the write. A write that arms the controller can therefore also load the clock choice. A write that disarms it cannot change the clock choice.

Word map (byte address = word × 4; address bits [1:0] are ignored):
- word 0: control, bit 0 run, bit 4 clock select.
- word 1: non-maskable line setup, bits [2:0] sense, bit 3 filter.
- word 2: event routing.
- word 3: asynchronous mode.
- word 4: debouncer enable.
- word 5: prescaler [7:0].
- words 8 and up: pin configuration.

Top module: `extint_cfg_bank`

## Requirements
- R1: After reset every stored field is zero, the controller is in `ST_OFF`, and every output and every read word is zero.
- R2: Run bit 0 of word 0 is writable in both states whenever strobe 0 is set; `run_o` and read bit 0 show the new value from the cycle after the write edge.
- R3: Clock select (word 0 bit 4; 1 = low-power 32 kHz clock, 0 = general clock) is loaded only when the stored state is `ST_OFF`. This includes the write that arms the controller. In `ST_ON` it is held.
- R4: A write that disarms the controller leaves the clock select at its old value.
- R5: While the state is `ST_ON`, writes to words 2, 3, 4, 5 and the pin configuration words are ignored, and they read back their prior values.
- R6: While the state is `ST_OFF`, those protected words accept writes, and only the bytes whose strobe is set change.
- R7: Word 1 (bits [2:0] sense, bit 3 filter) accepts byte-strobed writes in both states.
- R8: Words 6, 7 and every word above the last pin configuration word read as zero, and writes to them change nothing.
- R9: Pin p lives in word 8 + p/8. Its sense is bits [4·(p mod 8)+2 : 4·(p mod 8)] and its filter is bit 4·(p mod 8)+3. `pin_sense_o[3p+2:3p]` and `pin_filt_o[p]` carry these values.
- R10: A control write with strobe 0 clear changes neither the run state nor the clock select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write strobes |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| run_o | output | 1 | Controller running |
| lp_clk_sel_o | output | 1 | 1 = low-power 32 kHz clock, 0 = general clock |
| nmi_sense_o | output | 3 | Non-maskable line sense |
| nmi_filt_o | output | 1 | Non-maskable line filter enable |
| evt_en_o | output | NUM_PINS | Event routing per pin |
| async_o | output | NUM_PINS | Asynchronous mode per pin |
| deb_en_o | output | NUM_PINS | Debouncer enable per pin |
| deb_presc_o | output | 8 | Debounce prescaler |
| pin_sense_o | output | 3·NUM_PINS | Sense field per pin |
| pin_filt_o | output | NUM_PINS | Filter enable per pin |

## Verification
A wrong run state shows up at once on `run_o` and read bit 0. It also shows one write later: a protected word either takes data it should drop or drops data it should take, and that word reads back wrong on the very next read. A clock-select register that wrongly loads while running, or on a disarming write, shows on `lp_clk_sel_o` in the cycle after that write. The bench therefore sweeps every word, every strobe pattern and both states, and reads back the whole map and all decoded outputs after each write. A stray update anywhere is then caught before the next stimulus.

// File: rtl/extint_cfg_pkg.sv
package extint_cfg_pkg;

    localparam int BUS_W         = 32;
    localparam int STRB_W        = BUS_W / 8;

    // word indices of the map
    localparam int WORD_CTRL     = 0;
    localparam int WORD_NMI      = 1;
    localparam int WORD_EVT      = 2;
    localparam int WORD_ASYNC    = 3;
    localparam int WORD_DEBEN    = 4;
    localparam int WORD_PRESC    = 5;
    localparam int WORD_PINCFG   = 8;
    localparam int FIXED_SLOTS   = 6;

    // control word layout
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_CLK_BIT  = 4;

    // field widths
    localparam int NMI_W         = 4;
    localparam int PRESC_W       = 8;
    localparam int SENSE_W       = 3;
    localparam int PIN_FIELD_W   = 4;
    localparam int PINS_PER_WORD = BUS_W / PIN_FIELD_W;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } run_state_e;

    // map a slot index onto its word index
    function automatic int slot_word(input int slot);
        return (slot < FIXED_SLOTS) ? slot : WORD_PINCFG + slot - FIXED_SLOTS;
    endfunction

endpackage

// File: rtl/extint_cfg_decode.sv
module extint_cfg_decode
    import extint_cfg_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_SLOTS = 8
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_SLOTS-1:0] sel_o,
    output logic                 hit_o
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    logic              unused_lsb;

    assign word_idx   = addr_i[ADDR_W-1:2];
    assign unused_lsb = ^addr_i[1:0];

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            sel_o[i] = (int'(word_idx) == slot_word(i));
        end
    end

    assign hit_o = |sel_o;

    // R8: at most one storage word is addressed at a time
    always_comb begin
        p_sel_onehot_r8: assert ($onehot0(sel_o));
    end

endmodule

// File: rtl/extint_cfg_run_ctrl.sv
module extint_cfg_run_ctrl
    import extint_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,       // control word written with byte 0 strobed
    input  logic run_bit_i,
    input  logic clk_bit_i,
    output logic run_o,
    output logic lock_o,
    output logic clk_sel_o
);

    run_state_e state_q, state_d;
    logic       clk_q;
    logic       clk_load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: arm and disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (wr_i && run_bit_i)  state_d = ST_ON;
            ST_ON:  if (wr_i && !run_bit_i) state_d = ST_OFF;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run_o    = 1'b0;
        lock_o   = 1'b0;
        clk_load = 1'b0;
        unique case (state_q)
            ST_OFF: clk_load = wr_i;
            ST_ON: begin
                run_o  = 1'b1;
                lock_o = 1'b1;
            end
        endcase
    end

    // clock choice: judged against the state held before the write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
        end else if (clk_load) begin
            clk_q <= clk_bit_i;
        end
    end

    assign clk_sel_o = clk_q;

    p_run_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (run_o == $past(run_bit_i)));

    p_run_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(run_o));

    p_clk_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON) |=> $stable(clk_sel_o));

    p_clk_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && state_q == ST_OFF) |=> (clk_sel_o == $past(clk_bit_i)));

    p_disarm_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !run_bit_i && state_q == ST_ON) |=> (!run_o && $stable(clk_sel_o)));

endmodule

// File: rtl/extint_cfg_field.sv
module extint_cfg_field #(
    parameter int WIDTH   = 8,
    parameter bit PROTECT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel_i,
    input  logic                        we_i,
    input  logic                        lock_i,
    input  logic [WIDTH-1:0]            wdata_i,
    input  logic [(WIDTH+7)/8-1:0]      wstrb_i,
    output logic [WIDTH-1:0]            q_o
);

    localparam int NSTRB = (WIDTH + 7) / 8;

    logic [WIDTH-1:0] q_q;
    logic [WIDTH-1:0] bit_mask;
    logic             accept;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            bit_mask[i] = wstrb_i[i / 8];
        end
    end

    generate
        if (PROTECT) begin : g_guarded
            assign accept = sel_i && we_i && !lock_i;
        end else begin : g_open
            assign accept = sel_i && we_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else if (accept) begin
            q_q <= (q_q & ~bit_mask) | (wdata_i & bit_mask);
        end
    end

    assign q_o = q_q;

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && we_i) |=> $stable(q_q));

    generate
        if (PROTECT) begin : g_chk_guarded
            p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_i && we_i && lock_i) |=> $stable(q_q));
            p_open_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_i && we_i && !lock_i && (&wstrb_i)) |=> (q_q == $past(wdata_i)));
        end else begin : g_chk_open
            p_any_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_i && we_i && (&wstrb_i)) |=> (q_q == $past(wdata_i)));
        end
    endgenerate

    logic unused_nstrb;
    assign unused_nstrb = (NSTRB == 0);

endmodule

// File: rtl/extint_cfg_bank.sv
module extint_cfg_bank
    import extint_cfg_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic [3:0]                 bus_wstrb,
    input  logic                       bus_we,
    output logic [31:0]                bus_rdata,
    output logic                       run_o,
    output logic                       lp_clk_sel_o,
    output logic [2:0]                 nmi_sense_o,
    output logic                       nmi_filt_o,
    output logic [NUM_PINS-1:0]        evt_en_o,
    output logic [NUM_PINS-1:0]        async_o,
    output logic [NUM_PINS-1:0]        deb_en_o,
    output logic [7:0]                 deb_presc_o,
    output logic [3*NUM_PINS-1:0]      pin_sense_o,
    output logic [NUM_PINS-1:0]        pin_filt_o
);

    localparam int CFG_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
    localparam int NUM_SLOTS = FIXED_SLOTS + CFG_WORDS;
    localparam int PIN_STRB  = (NUM_PINS + 7) / 8;

    logic [NUM_SLOTS-1:0] sel;
    logic                 hit;
    logic                 lock;
    logic                 ctrl_wr;
    logic [NMI_W-1:0]     nmi_q;
    logic [NUM_PINS-1:0]  evt_q, async_q, deben_q;
    logic [PRESC_W-1:0]   presc_q;
    logic [BUS_W-1:0]     cfg_q [CFG_WORDS];
    logic [BUS_W-1:0]     rd_words [NUM_SLOTS];

    extint_cfg_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_decode (
        .addr_i (bus_addr),
        .sel_o  (sel),
        .hit_o  (hit)
    );

    assign ctrl_wr = sel[WORD_CTRL] && bus_we && bus_wstrb[0];

    extint_cfg_run_ctrl u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (ctrl_wr),
        .run_bit_i (bus_wdata[CTRL_RUN_BIT]),
        .clk_bit_i (bus_wdata[CTRL_CLK_BIT]),
        .run_o     (run_o),
        .lock_o    (lock),
        .clk_sel_o (lp_clk_sel_o)
    );

    extint_cfg_field #(.WIDTH(NMI_W), .PROTECT(1'b0)) u_nmi (
        .clk (clk), .rst_n (rst_n), .sel_i (sel[WORD_NMI]), .we_i (bus_we),
        .lock_i (lock), .wdata_i (bus_wdata[NMI_W-1:0]),
        .wstrb_i (bus_wstrb[0:0]), .q_o (nmi_q)
    );

    extint_cfg_field #(.WIDTH(NUM_PINS), .PROTECT(1'b1)) u_evt (
        .clk (clk), .rst_n (rst_n), .sel_i (sel[WORD_EVT]), .we_i (bus_we),
        .lock_i (lock), .wdata_i (bus_wdata[NUM_PINS-1:0]),
        .wstrb_i (bus_wstrb[PIN_STRB-1:0]), .q_o (evt_q)
    );

    extint_cfg_field #(.WIDTH(NUM_PINS), .PROTECT(1'b1)) u_async (
        .clk (clk), .rst_n (rst_n), .sel_i (sel[WORD_ASYNC]), .we_i (bus_we),
        .lock_i (lock), .wdata_i (bus_wdata[NUM_PINS-1:0]),
        .wstrb_i (bus_wstrb[PIN_STRB-1:0]), .q_o (async_q)
    );

    extint_cfg_field #(.WIDTH(NUM_PINS), .PROTECT(1'b1)) u_deben (
        .clk (clk), .rst_n (rst_n), .sel_i (sel[WORD_DEBEN]), .we_i (bus_we),
        .lock_i (lock), .wdata_i (bus_wdata[NUM_PINS-1:0]),
        .wstrb_i (bus_wstrb[PIN_STRB-1:0]), .q_o (deben_q)
    );

    extint_cfg_field #(.WIDTH(PRESC_W), .PROTECT(1'b1)) u_presc (
        .clk (clk), .rst_n (rst_n), .sel_i (sel[WORD_PRESC]), .we_i (bus_we),
        .lock_i (lock), .wdata_i (bus_wdata[PRESC_W-1:0]),
        .wstrb_i (bus_wstrb[0:0]), .q_o (presc_q)
    );

    generate
        for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
            extint_cfg_field #(.WIDTH(BUS_W), .PROTECT(1'b1)) u_cfg (
                .clk (clk), .rst_n (rst_n), .sel_i (sel[FIXED_SLOTS + w]),
                .we_i (bus_we), .lock_i (lock), .wdata_i (bus_wdata),
                .wstrb_i (bus_wstrb), .q_o (cfg_q[w])
            );
        end

        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            localparam int WI = p / PINS_PER_WORD;
            localparam int LO = PIN_FIELD_W * (p % PINS_PER_WORD);
            assign pin_sense_o[SENSE_W*p +: SENSE_W] = cfg_q[WI][LO +: SENSE_W];
            assign pin_filt_o[p]                     = cfg_q[WI][LO + SENSE_W];
        end
    endgenerate

    // words as seen on the bus
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            rd_words[s] = '0;
        end
        rd_words[WORD_CTRL][CTRL_RUN_BIT]   = run_o;
        rd_words[WORD_CTRL][CTRL_CLK_BIT]   = lp_clk_sel_o;
        rd_words[WORD_NMI][NMI_W-1:0]       = nmi_q;
        rd_words[WORD_EVT][NUM_PINS-1:0]    = evt_q;
        rd_words[WORD_ASYNC][NUM_PINS-1:0]  = async_q;
        rd_words[WORD_DEBEN][NUM_PINS-1:0]  = deben_q;
        rd_words[WORD_PRESC][PRESC_W-1:0]   = presc_q;
        for (int w = 0; w < CFG_WORDS; w++) begin
            rd_words[FIXED_SLOTS + w] = cfg_q[w];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            bus_rdata = bus_rdata | (sel[s] ? rd_words[s] : '0);
        end
    end

    assign nmi_sense_o = nmi_q[SENSE_W-1:0];
    assign nmi_filt_o  = nmi_q[SENSE_W];
    assign evt_en_o    = evt_q;
    assign async_o     = async_q;
    assign deb_en_o    = deben_q;
    assign deb_presc_o = presc_q;

    // R8: unmapped words return zero
    always_comb begin
        if (!hit) begin
            p_unmapped_zero_r8: assert (bus_rdata == '0);
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!run_o && !lp_clk_sel_o && evt_en_o == '0 &&
                          deb_presc_o == '0 && pin_filt_o == '0));

    p_lock_is_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock == run_o);

endmodule

// File: tb/extint_cfg_bank_bench.sv
`timescale 1ns/1ps
module extint_cfg_bank_bench;

    localparam int NP     = 16;
    localparam int AW     = 6;
    localparam int CW     = NP / 8;
    localparam int NWORDS = 1 << (AW - 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [3:0]      bus_wstrb = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_rdata;
    logic            run_o, lp_clk_sel_o, nmi_filt_o;
    logic [2:0]      nmi_sense_o;
    logic [NP-1:0]   evt_en_o, async_o, deb_en_o, pin_filt_o;
    logic [7:0]      deb_presc_o;
    logic [3*NP-1:0] pin_sense_o;

    always #2 clk = ~clk;

    extint_cfg_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_extint_cfg_bank (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb), .bus_we (bus_we), .bus_rdata (bus_rdata),
        .run_o (run_o), .lp_clk_sel_o (lp_clk_sel_o), .nmi_sense_o (nmi_sense_o),
        .nmi_filt_o (nmi_filt_o), .evt_en_o (evt_en_o), .async_o (async_o),
        .deb_en_o (deb_en_o), .deb_presc_o (deb_presc_o),
        .pin_sense_o (pin_sense_o), .pin_filt_o (pin_filt_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    logic          m_run, m_clk;
    logic [3:0]    m_nmi;
    logic [NP-1:0] m_evt, m_async, m_deben;
    logic [7:0]    m_presc;
    logic [31:0]   m_cfg [CW];
    logic [31:0]   lcg = 32'h1234_5678;

    function automatic logic [31:0] byte_mask(input logic [3:0] s);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{s[b]}};
        return m;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] s);
        return (old & ~byte_mask(s)) | (d & byte_mask(s));
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r = '0;
        if (w == 0)      begin r[0] = m_run; r[4] = m_clk; end
        else if (w == 1) r[3:0] = m_nmi;
        else if (w == 2) r[NP-1:0] = m_evt;
        else if (w == 3) r[NP-1:0] = m_async;
        else if (w == 4) r[NP-1:0] = m_deben;
        else if (w == 5) r[7:0] = m_presc;
        else if (w >= 8 && w < 8 + CW) r = m_cfg[w-8];
        return r;
    endfunction

    function automatic string tag_of(input int w);
        if (w == 0) return "R3";
        if (w == 1) return "R7";
        if (w >= 2 && w <= 5) return m_run ? "R5" : "R6";
        if (w >= 8 && w < 8 + CW) return m_run ? "R5" : "R9";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input int w, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] t;
        if (w == 0) begin
            if (s[0]) begin
                if (!m_run) m_clk = d[4];
                m_run = d[0];
            end
        end else if (w == 1) begin
            t = merge({28'b0, m_nmi}, d, s); m_nmi = t[3:0];
        end else if (!m_run) begin
            if (w == 2)      begin t = merge({{(32-NP){1'b0}}, m_evt}, d, s);   m_evt   = t[NP-1:0]; end
            else if (w == 3) begin t = merge({{(32-NP){1'b0}}, m_async}, d, s); m_async = t[NP-1:0]; end
            else if (w == 4) begin t = merge({{(32-NP){1'b0}}, m_deben}, d, s); m_deben = t[NP-1:0]; end
            else if (w == 5) begin t = merge({24'b0, m_presc}, d, s); m_presc = t[7:0]; end
            else if (w >= 8 && w < 8 + CW) m_cfg[w-8] = merge(m_cfg[w-8], d, s);
        end
    endtask

    task automatic bus_write(input int w, input logic [31:0] d, input logic [3:0] s);
        model_write(w, d, s);
        @(negedge clk);
        bus_addr  = AW'((w << 2) | int'(d[1:0]));
        bus_wdata = d;
        bus_wstrb = s;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic check_all();
        logic [3*NP-1:0] es;
        logic [NP-1:0]   ef;
        for (int w = 0; w < NWORDS; w++) begin
            @(negedge clk);
            bus_addr = AW'(w << 2);
            #1;
            check(tag_of(w), 64'(bus_rdata), 64'(exp_word(w)));
        end
        for (int p = 0; p < NP; p++) begin
            es[3*p +: 3] = m_cfg[p/8][4*(p%8) +: 3];
            ef[p]        = m_cfg[p/8][4*(p%8) + 3];
        end
        check("R2 run_o", 64'(run_o), 64'(m_run));
        check("R3 lp_clk_sel_o", 64'(lp_clk_sel_o), 64'(m_clk));
        check("R7 nmi outputs", 64'({nmi_filt_o, nmi_sense_o}), 64'(m_nmi));
        check("R5 R6 evt/async/deb", 64'({evt_en_o, async_o, deb_en_o, deb_presc_o}),
              64'({m_evt, m_async, m_deben, m_presc}));
        check("R9 pin_sense_o", 64'(pin_sense_o), 64'(es));
        check("R9 pin_filt_o", 64'(pin_filt_o), 64'(ef));
    endtask

    initial begin
        m_run = 0; m_clk = 0; m_nmi = '0; m_evt = '0; m_async = '0;
        m_deben = '0; m_presc = '0;
        for (int w = 0; w < CW; w++) m_cfg[w] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        for (int w = 0; w < NWORDS; w++) begin
            @(negedge clk);
            bus_addr = AW'(w << 2);
            #1;
            check("R1 reset readback", 64'(bus_rdata), 64'd0);
        end
        check("R1 reset outputs", 64'({run_o, lp_clk_sel_o, nmi_filt_o, nmi_sense_o, deb_presc_o}), 64'd0);
        check("R1 reset pin outputs", 64'(pin_sense_o), 64'd0);

        // R3: arming write also loads clock select
        bus_write(0, 32'h11, 4'hF);
        check("R3 clk loaded on arm", 64'(lp_clk_sel_o), 64'd1);
        check("R2 armed", 64'(run_o), 64'd1);
        // R3: held while running
        bus_write(0, 32'h01, 4'hF);
        check("R3 clk held while on", 64'(lp_clk_sel_o), 64'd1);
        // R7: non-maskable setup writable while running
        bus_write(1, 32'hA, 4'h1);
        check("R7 nmi while on", 64'({nmi_filt_o, nmi_sense_o}), 64'hA);
        // R4: disarm keeps clock select
        bus_write(0, 32'h00, 4'hF);
        check("R4 disarmed", 64'(run_o), 64'd0);
        check("R4 clk kept on disarm", 64'(lp_clk_sel_o), 64'd1);
        bus_write(0, 32'h00, 4'hF);
        check("R3 clk cleared while off", 64'(lp_clk_sel_o), 64'd0);
        // R10: strobe 0 clear
        bus_write(0, 32'h11, 4'hE);
        check("R10 no strobe no run", 64'(run_o), 64'd0);
        check("R10 no strobe no clk", 64'(lp_clk_sel_o), 64'd0);
        check_all();

        // sweep: both states, every word, every strobe pattern
        for (int st = 0; st < 2; st++) begin
            for (int w = 0; w < NWORDS; w++) begin
                for (int s = 0; s < 16; s++) begin
                    bus_write(0, 32'(st), 4'hF);
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    bus_write(w, lcg, 4'(s));
                    check_all();
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1..all watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule